// File: doc/BRIEF.md
# Pairing Loop Line-Function Step Unit

This block runs the base-field side of the main loop of a characteristic-three pairing. A start strobe loads the two coordinates of two curve points over GF(3^M). Each loop step then raises the first point's coordinates to the ninth power and forms the sum mu = alpha + x + d. Two serial base-field multipliers run at the same time to form mu·mu and beta·y. The result is a sparse element of the degree-six extension, which the surrounding accumulator multiplies into its running product.

The unit issues one element per step with a one-cycle valid strobe. It negates its stored y value and steps a small trit counter after each step, and it raises done together with the M-th element. A curve-sign input chooses the start value of the counter and the direction in which it moves. The extension-field accumulator is outside this block.

The field is GF(3)[x] modulo a trinomial x^M + CK·x^K + C0. All three of M, K and the coefficients are parameters, and the default is x^5 + 2x + 1.

Top module: `tate_line_unit`

## Requirements
- R1: Each trit uses a 2-bit code: 00 for 0, 01 for 1 and 10 for 2. Trit j of a base-field element sits at bits [2j+1:2j]. Coefficient i of the output element sits at bits [2M·i +: 2M], and the basis order is 1, σ, ρ, σρ, ρ², σρ².
- R2: After reset, busy, line_valid and done are low and line_elem is all zero.
- R3: A start pulse while the unit is idle captures four values: alpha = px, beta = py, x = qx³ and y = qy³. It also sets d = M mod 3 when curve_minus is 0, or d = (−M) mod 3 when curve_minus is 1.
- R4: At the beginning of each step, alpha and beta are each replaced by their ninth power, applied as two successive cubings in the field.
- R5: Each step emits the element (−mu², beta·y, −mu, 0, −1, 0), where mu = alpha + x with d added to the constant trit only.
- R6: After each emission, y is negated. d is decremented mod 3 when curve_minus is 0, and incremented mod 3 when curve_minus is 1.
- R7: One run produces exactly M line_valid pulses. done is high in the same cycle as the M-th pulse, and from that cycle on busy is low.
- R8: The first line_valid appears M+4 cycles after the clock edge that samples start. Each later pulse follows the one before it by exactly M+4 cycles, and every pulse lasts one cycle.
- R9: A start pulse while busy is high is ignored. The run in progress and its outputs are not affected.
- R10: Whenever line_valid is high, no trit of line_elem carries the code 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run, sampled only while idle |
| curve_minus | input | 1 | 0 selects the plus curve, 1 selects the minus curve |
| px | input | 2M | x coordinate of the first point |
| py | input | 2M | y coordinate of the first point |
| qx | input | 2M | x coordinate of the second point |
| qy | input | 2M | y coordinate of the second point |
| busy | output | 1 | A run is in progress |
| line_valid | output | 1 | One-cycle strobe that marks line_elem as new |
| line_elem | output | 12M | Sparse extension element of the current step |
| done | output | 1 | One-cycle strobe together with the last element |

## Verification
The bound checker watches the shape of the output stream on every cycle. It checks that each valid pulse lasts one cycle and that pulses are exactly M+4 cycles apart. It also checks that done coincides with the M-th pulse and leaves the unit idle, that the fixed coefficients hold 0, −1 and 0, and that no illegal trit code appears. The field arithmetic itself can only be shown by the bench's scenarios. These compare every emitted element against an independent model across both curve signs, using zero, all-two and random coordinates. The same scenarios show that the ninth-power update, the y negation and the counter direction carry correctly from step to step, and that a start pulse in the middle of a run changes nothing.

// File: rtl/tlu_pkg.sv
package tlu_pkg;

    typedef logic [1:0] trit_t;

    localparam trit_t TZ = 2'b00;
    localparam trit_t TP = 2'b01;
    localparam trit_t TM = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CUBE1,
        ST_CUBE2,
        ST_GO,
        ST_WAIT
    } step_state_e;

    typedef struct packed {
        logic load;
        logic cube;
        logic mul_go;
        logic emit;
    } step_ctl_t;

    function automatic int t2i(trit_t t);
        case (t)
            TP:      return 1;
            TM:      return 2;
            default: return 0;
        endcase
    endfunction

    function automatic trit_t i2t(int v);
        case (((v % 3) + 3) % 3)
            1:       return TP;
            2:       return TM;
            default: return TZ;
        endcase
    endfunction

    function automatic trit_t t_add(trit_t a, trit_t b);
        return i2t(t2i(a) + t2i(b));
    endfunction

    function automatic trit_t t_neg(trit_t a);
        return i2t(3 - t2i(a));
    endfunction

    function automatic trit_t t_sub(trit_t a, trit_t b);
        return t_add(a, t_neg(b));
    endfunction

    function automatic trit_t t_mul(trit_t a, trit_t b);
        return i2t(t2i(a) * t2i(b));
    endfunction

endpackage

// File: rtl/gf3m_cuber.sv
module gf3m_cuber
    import tlu_pkg::*;
#(
    parameter int M  = 5,
    parameter int K  = 1,
    parameter int CK = 2,
    parameter int C0 = 1
) (
    input  logic [2*M-1:0] a,
    output logic [2*M-1:0] y
);
    localparam int PL = 3*M - 2;
    localparam trit_t CKT = i2t(CK);
    localparam trit_t C0T = i2t(C0);

    trit_t p [PL];

    always_comb begin
        for (int i = 0; i < PL; i++) p[i] = TZ;
        // Frobenius spread: coefficient i moves to degree 3i
        for (int i = 0; i < M; i++) p[3*i] = a[2*i +: 2];
        // fold high degrees with x^M = -(CK x^K + C0)
        for (int deg = PL - 1; deg >= M; deg--) begin
            p[deg-M+K] = t_sub(p[deg-M+K], t_mul(p[deg], CKT));
            p[deg-M]   = t_sub(p[deg-M],   t_mul(p[deg], C0T));
            p[deg]     = TZ;
        end
        for (int i = 0; i < M; i++) y[2*i +: 2] = p[i];
    end

endmodule

// File: rtl/gf3m_serial_mul.sv
module gf3m_serial_mul
    import tlu_pkg::*;
#(
    parameter int M  = 5,
    parameter int K  = 1,
    parameter int CK = 2,
    parameter int C0 = 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           go,
    input  logic [2*M-1:0] a,
    input  logic [2*M-1:0] b,
    output logic           done,
    output logic [2*M-1:0] p
);
    localparam int EW = 2*M;
    localparam int CW = $clog2(M + 1);
    localparam trit_t CKT = i2t(CK);
    localparam trit_t C0T = i2t(C0);

    logic [EW-1:0] a_q, b_q, acc_q, acc_d;
    logic [CW-1:0] cnt_q;
    logic          run_q, done_q;

    // acc <- acc*x mod f + b_top * a   (most significant trit of b first)
    always_comb begin
        trit_t top, bt;
        top = acc_q[EW-2 +: 2];
        bt  = b_q[EW-2 +: 2];
        acc_d = {acc_q[EW-3:0], 2'b00};
        acc_d[2*K +: 2] = t_sub(acc_d[2*K +: 2], t_mul(top, CKT));
        acc_d[1:0]      = t_sub(acc_d[1:0],      t_mul(top, C0T));
        for (int j = 0; j < M; j++)
            acc_d[2*j +: 2] = t_add(acc_d[2*j +: 2], t_mul(bt, a_q[2*j +: 2]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q    <= '0;
            b_q    <= '0;
            acc_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go && !run_q) begin
                a_q   <= a;
                b_q   <= b;
                acc_q <= '0;
                cnt_q <= '0;
                run_q <= 1'b1;
            end else if (run_q) begin
                acc_q <= acc_d;
                b_q   <= {b_q[EW-3:0], 2'b00};
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CW'(M - 1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done = done_q;
    assign p    = acc_q;

endmodule

// File: rtl/tlu_step_ctrl.sv
module tlu_step_ctrl
    import tlu_pkg::*;
#(
    parameter int M = 5
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      mul_done_a,
    input  logic      mul_done_b,
    output step_ctl_t ctl,
    output logic      last,
    output logic      busy
);
    localparam int SW = (M > 1) ? $clog2(M) : 1;

    step_state_e   st_q, st_d;
    logic [SW-1:0] step_q;
    logic          got_a_q, got_b_q, both;

    assign both = (got_a_q || mul_done_a) && (got_b_q || mul_done_b);

    always_comb begin
        ctl  = '0;
        st_d = st_q;
        last = 1'b0;
        case (st_q)
            ST_IDLE: if (start) begin
                ctl.load = 1'b1;
                st_d     = ST_CUBE1;
            end
            ST_CUBE1: begin
                ctl.cube = 1'b1;
                st_d     = ST_CUBE2;
            end
            ST_CUBE2: begin
                ctl.cube = 1'b1;
                st_d     = ST_GO;
            end
            ST_GO: begin
                ctl.mul_go = 1'b1;
                st_d       = ST_WAIT;
            end
            ST_WAIT: if (both) begin
                ctl.emit = 1'b1;
                last     = (step_q == SW'(M - 1));
                st_d     = last ? ST_IDLE : ST_CUBE1;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            step_q  <= '0;
            got_a_q <= 1'b0;
            got_b_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (ctl.load) step_q <= '0;
            else if (ctl.emit) step_q <= step_q + 1'b1;
            if (ctl.mul_go || ctl.emit) begin
                got_a_q <= 1'b0;
                got_b_q <= 1'b0;
            end else begin
                if (mul_done_a) got_a_q <= 1'b1;
                if (mul_done_b) got_b_q <= 1'b1;
            end
        end
    end

    assign busy = (st_q != ST_IDLE);

endmodule

// File: rtl/tate_line_unit.sv
module tate_line_unit
    import tlu_pkg::*;
#(
    parameter int M  = 5,
    parameter int K  = 1,
    parameter int CK = 2,
    parameter int C0 = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            curve_minus,
    input  logic [2*M-1:0]  px,
    input  logic [2*M-1:0]  py,
    input  logic [2*M-1:0]  qx,
    input  logic [2*M-1:0]  qy,
    output logic            busy,
    output logic            line_valid,
    output logic [12*M-1:0] line_elem,
    output logic            done
);
    localparam int    EW     = 2*M;
    localparam int    LW     = 12*M;
    localparam int    NCUBE  = 4;
    localparam trit_t D_PLUS  = i2t(M);
    localparam trit_t D_MINUS = i2t(-M);
    localparam logic [EW-1:0] NEG_ONE = {{(EW-2){1'b0}}, TM};

    function automatic logic [EW-1:0] el_neg(logic [EW-1:0] v);
        logic [EW-1:0] r;
        for (int j = 0; j < M; j++) r[2*j +: 2] = t_neg(v[2*j +: 2]);
        return r;
    endfunction

    // loop state
    logic [EW-1:0] alpha_q, beta_q, x_q, y_q;
    trit_t         d_q;
    logic          minus_q;
    logic [LW-1:0] line_q;
    logic          valid_q, done_q;

    step_ctl_t ctl;
    logic      last;
    logic      done_a, done_b;
    logic [EW-1:0] prod_a, prod_b, mu;

    logic [EW-1:0] cube_in  [NCUBE];
    logic [EW-1:0] cube_out [NCUBE];

    assign cube_in[0] = qx;
    assign cube_in[1] = qy;
    assign cube_in[2] = alpha_q;
    assign cube_in[3] = beta_q;

    for (genvar g = 0; g < NCUBE; g++) begin : g_cube
        gf3m_cuber #(.M(M), .K(K), .CK(CK), .C0(C0)) u_cube (
            .a (cube_in[g]),
            .y (cube_out[g])
        );
    end

    always_comb begin
        for (int j = 0; j < M; j++)
            mu[2*j +: 2] = t_add(alpha_q[2*j +: 2], x_q[2*j +: 2]);
        mu[1:0] = t_add(mu[1:0], d_q);
    end

    tlu_step_ctrl #(.M(M)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .mul_done_a (done_a),
        .mul_done_b (done_b),
        .ctl        (ctl),
        .last       (last),
        .busy       (busy)
    );

    gf3m_serial_mul #(.M(M), .K(K), .CK(CK), .C0(C0)) u_mul_mu (
        .clk (clk), .rst (rst), .go (ctl.mul_go),
        .a (mu), .b (mu), .done (done_a), .p (prod_a)
    );

    gf3m_serial_mul #(.M(M), .K(K), .CK(CK), .C0(C0)) u_mul_by (
        .clk (clk), .rst (rst), .go (ctl.mul_go),
        .a (beta_q), .b (y_q), .done (done_b), .p (prod_b)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            alpha_q <= '0;
            beta_q  <= '0;
            x_q     <= '0;
            y_q     <= '0;
            d_q     <= TZ;
            minus_q <= 1'b0;
            line_q  <= '0;
            valid_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            done_q  <= 1'b0;
            if (ctl.load) begin
                alpha_q <= px;
                beta_q  <= py;
                x_q     <= cube_out[0];
                y_q     <= cube_out[1];
                d_q     <= curve_minus ? D_MINUS : D_PLUS;
                minus_q <= curve_minus;
            end
            if (ctl.cube) begin
                alpha_q <= cube_out[2];
                beta_q  <= cube_out[3];
            end
            if (ctl.emit) begin
                line_q  <= {{EW{1'b0}}, NEG_ONE, {EW{1'b0}},
                            el_neg(mu), prod_b, el_neg(prod_a)};
                valid_q <= 1'b1;
                done_q  <= last;
                y_q     <= el_neg(y_q);
                d_q     <= minus_q ? t_add(d_q, TP) : t_sub(d_q, TP);
            end
        end
    end

    assign line_valid = valid_q;
    assign line_elem  = line_q;
    assign done       = done_q;

endmodule

// File: rtl/tate_line_unit_chk.sv
module tate_line_unit_chk #(
    parameter int M = 5
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            busy,
    input logic            line_valid,
    input logic [12*M-1:0] line_elem,
    input logic            done
);
    localparam int EW = 2*M;
    localparam logic [EW-1:0] NEG_ONE = {{(EW-2){1'b0}}, 2'b10};

    logic [31:0] vcount_q, gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vcount_q <= '0;
            gap_q    <= '0;
        end else begin
            if (start && !busy) vcount_q <= '0;
            else if (line_valid) vcount_q <= vcount_q + 1;
            if (line_valid) gap_q <= 32'd1;
            else if (gap_q != '1) gap_q <= gap_q + 1;
        end
    end

    function automatic logic codes_ok(logic [12*M-1:0] v);
        for (int j = 0; j < 6*M; j++)
            if (v[2*j +: 2] == 2'b11) return 1'b0;
        return 1'b1;
    endfunction

    a_r7_done_on_last: assert property (@(posedge clk) disable iff (rst)
        done |-> line_valid && vcount_q == 32'(M - 1));

    a_r7_idle_after_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r9_valid_inside_run: assert property (@(posedge clk) disable iff (rst)
        line_valid && !done |-> busy);

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        line_valid |=> !line_valid);

    a_r8_step_spacing: assert property (@(posedge clk) disable iff (rst)
        line_valid && vcount_q != 0 |-> gap_q == 32'(M + 4));

    a_r5_fixed_coeffs: assert property (@(posedge clk) disable iff (rst)
        line_valid |-> line_elem[3*EW +: EW] == '0 && line_elem[5*EW +: EW] == '0
                       && line_elem[4*EW +: EW] == NEG_ONE);

    a_r10_trit_codes: assert property (@(posedge clk) disable iff (rst)
        line_valid |-> codes_ok(line_elem));

endmodule

bind tate_line_unit tate_line_unit_chk #(.M(M)) u_chk (.*);

// File: tb/tb_tate_line_unit.sv
module tb_tate_line_unit;
    localparam int M  = 5;
    localparam int K  = 1;
    localparam int CK = 2;
    localparam int C0 = 1;
    localparam int EW = 2*M;
    localparam int LW = 12*M;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic curve_minus = 1'b0;
    logic [EW-1:0] px = '0, py = '0, qx = '0, qy = '0;
    logic busy, line_valid, done;
    logic [LW-1:0] line_elem;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    tate_line_unit #(.M(M), .K(K), .CK(CK), .C0(C0)) dut (
        .clk (clk), .rst (rst), .start (start), .curve_minus (curve_minus),
        .px (px), .py (py), .qx (qx), .qy (qy),
        .busy (busy), .line_valid (line_valid), .line_elem (line_elem), .done (done)
    );

    // ---------------- reference arithmetic ----------------
    function automatic int m3(int v);
        return ((v % 3) + 3) % 3;
    endfunction

    function automatic int gt(logic [EW-1:0] v, int j);
        return (v[2*j +: 2] == 2'b01) ? 1 : (v[2*j +: 2] == 2'b10) ? 2 : 0;
    endfunction

    function automatic logic [1:0] enc(int v);
        return (m3(v) == 1) ? 2'b01 : (m3(v) == 2) ? 2'b10 : 2'b00;
    endfunction

    function automatic logic [EW-1:0] mulm(logic [EW-1:0] a, logic [EW-1:0] b);
        int p [2*M-1];
        logic [EW-1:0] r;
        for (int i = 0; i < 2*M-1; i++) p[i] = 0;
        for (int i = 0; i < M; i++)
            for (int j = 0; j < M; j++)
                p[i+j] = m3(p[i+j] + gt(a, i) * gt(b, j));
        for (int deg = 2*M-2; deg >= M; deg--) begin
            p[deg-M+K] = m3(p[deg-M+K] - p[deg] * CK);
            p[deg-M]   = m3(p[deg-M]   - p[deg] * C0);
            p[deg] = 0;
        end
        for (int i = 0; i < M; i++) r[2*i +: 2] = enc(p[i]);
        return r;
    endfunction

    function automatic logic [EW-1:0] cubem(logic [EW-1:0] a);
        return mulm(a, mulm(a, a));
    endfunction

    function automatic logic [EW-1:0] addm(logic [EW-1:0] a, logic [EW-1:0] b);
        logic [EW-1:0] r;
        for (int i = 0; i < M; i++) r[2*i +: 2] = enc(gt(a, i) + gt(b, i));
        return r;
    endfunction

    function automatic logic [EW-1:0] negm(logic [EW-1:0] a);
        logic [EW-1:0] r;
        for (int i = 0; i < M; i++) r[2*i +: 2] = enc(-gt(a, i));
        return r;
    endfunction

    function automatic logic [EW-1:0] rnd_el();
        logic [EW-1:0] r;
        for (int i = 0; i < M; i++) r[2*i +: 2] = enc(int'($urandom % 3));
        return r;
    endfunction

    // ---------------- checking ----------------
    task automatic check(input bit ok, input string req, input string what,
                         input logic [LW-1:0] act, input logic [LW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_case(input logic [EW-1:0] ax, input logic [EW-1:0] ay,
                            input logic [EW-1:0] bx, input logic [EW-1:0] by,
                            input logic minus, input bit poke);
        logic [LW-1:0] expv [M];
        logic [EW-1:0] al, be, xx, yy, mu, c0, c1, c2;
        int d;
        int n;
        al = ax; be = ay; xx = cubem(bx); yy = cubem(by);
        d  = minus ? m3(-M) : m3(M);
        for (int s = 0; s < M; s++) begin
            al = cubem(cubem(al));
            be = cubem(cubem(be));
            mu = addm(al, xx);
            mu[1:0] = enc(gt(mu, 0) + d);
            c0 = negm(mulm(mu, mu));
            c1 = mulm(be, yy);
            c2 = negm(mu);
            expv[s] = {{EW{1'b0}}, enc(2) | {EW{1'b0}}, {EW{1'b0}}, c2, c1, c0};
            yy = negm(yy);
            d  = minus ? m3(d + 1) : m3(d - 1);
        end

        @(negedge clk);
        px = ax; py = ay; qx = bx; qy = by; curve_minus = minus; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        for (int s = 0; s < M; s++) begin
            if (s > 0) begin
                @(negedge clk);
                n = 1;
            end
            while (!line_valid && n < 200) begin
                if (poke && s == 1 && n == 2) begin
                    px = rnd_el(); qy = rnd_el(); curve_minus = ~minus; start = 1'b1;
                end else begin
                    start = 1'b0;
                end
                @(negedge clk);
                n++;
            end
            start = 1'b0;
            check(n == M + 4, "R8", "step latency", LW'(n), LW'(M + 4));
            check(line_elem == expv[s], poke ? "R9" : "R5", "line element",
                  line_elem, expv[s]);
            check(line_elem[EW-1:0] == expv[s][EW-1:0] &&
                  line_elem[2*EW +: EW] == expv[s][2*EW +: EW],
                  "R4", "mu-based coefficients", line_elem, expv[s]);
            check(line_elem[EW +: EW] == expv[s][EW +: EW], "R6",
                  "beta*y coefficient", line_elem, expv[s]);
            if (s == 0)
                check(line_elem == expv[0], "R3", "first element after load",
                      line_elem, expv[0]);
            check(done == (s == M - 1), "R7", "done strobe", LW'(done),
                  LW'(s == M - 1));
        end
        @(negedge clk);
        check(!busy && !line_valid && !done, "R7", "idle after run",
              LW'({busy, line_valid, done}), '0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [EW-1:0] twos, one;
        void'($urandom(32'h1d5_7a3));
        for (int i = 0; i < M; i++) twos[2*i +: 2] = 2'b10;
        one = {{(EW-2){1'b0}}, 2'b01};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !line_valid && !done, "R2", "control outputs after reset",
              LW'({busy, line_valid, done}), '0);
        check(line_elem == '0, "R2", "element after reset", line_elem, '0);

        // directed corners
        run_case('0, '0, '0, '0, 1'b0, 1'b0);
        run_case('0, '0, '0, '0, 1'b1, 1'b0);
        run_case(twos, twos, twos, twos, 1'b0, 1'b0);
        run_case(twos, one, one, twos, 1'b1, 1'b0);
        run_case(one, one, one, one, 1'b0, 1'b0);

        // random coordinates on both curves (R1 packing covered by every compare)
        for (int r = 0; r < 12; r++)
            run_case(rnd_el(), rnd_el(), rnd_el(), rnd_el(), 1'(r % 2), 1'b0);

        // start pulses during a run are ignored
        run_case(rnd_el(), rnd_el(), rnd_el(), rnd_el(), 1'b0, 1'b1);
        run_case(rnd_el(), rnd_el(), rnd_el(), rnd_el(), 1'b1, 1'b1);

        // R1: constant coefficient -1 uses code 10 in the lowest trit of coefficient 4
        check(line_elem[4*EW +: 2] == 2'b10, "R1", "minus-one code",
              LW'(line_elem[4*EW +: 2]), LW'(2'b10));
        // R10: no 11 code in the last element
        begin
            bit bad = 1'b0;
            for (int j = 0; j < 6*M; j++)
                if (line_elem[2*j +: 2] == 2'b11) bad = 1'b1;
            check(!bad, "R10", "trit codes", line_elem, line_elem);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule